// File: doc/BRIEF.md
# Oscillator Clock Loss Monitor

This block watches a free-running oscillator clock from a separate reference clock domain and reports when that oscillator has stopped. The oscillator is sampled by a chain of reference-domain flops, and its rising edges are detected there. A timeout counter counts reference cycles since the last detected edge. If the count reaches a set limit with no new edge, the block raises a one-cycle fail event. That event can also serve as the start signal for a separate clock quality check.

A policy input chooses how the block answers a fail. With self-clock fallback selected, the block raises a request to switch to the internal self-clock. With it deselected, the block raises a system reset request instead. Each request stays asserted until the block's own reset. A monitor enable input gates the whole function. While it is low, the counter is held at zero and no fail can occur.

Top module: `osc_loss_monitor`

## Requirements
- R1: With the monitor enabled and no oscillator rising edge detected, `fail_pulse` goes high exactly TIMEOUT reference cycles after the count last restarted. The count restarts on reset release, on re-enable, or on the cycle that consumes a detected edge. It is low in every cycle before that.
- R2: `fail_pulse` is high for exactly one reference cycle per loss episode. It does not pulse again until a new oscillator rising edge has been detected.
- R3: If `scm_en` is 1 when a fail occurs, `scm_req` rises in the same cycle as `fail_pulse` and stays high until reset. A fail with `scm_en` = 1 does not raise `rst_req`.
- R4: If `scm_en` is 0 when a fail occurs, `rst_req` rises in the same cycle as `fail_pulse` and stays high until reset. A fail with `scm_en` = 0 does not raise `scm_req`.
- R5: While `mon_en` is 0, no fail occurs and neither request rises. Dropping `mon_en` for even one cycle clears the count, so a full TIMEOUT is needed after it returns to 1.
- R6: An oscillator whose rising edges come every P reference cycles never causes a fail when P ≤ TIMEOUT. It does cause a fail when P > TIMEOUT.
- R7: Synchronous active-high `rst` clears `fail_pulse`, `scm_req`, `rst_req`, the synchronizer and the counter.
- R8: After a fail, a new oscillator rising edge re-arms the monitor. A further loss then produces another fail after TIMEOUT cycles, plus SYNC_STAGES + 1 cycles of edge-detect latency measured from the oscillator rise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock, independent of the oscillator |
| rst | input | 1 | Synchronous active-high reset |
| osc_clk | input | 1 | Oscillator clock under observation (asynchronous) |
| mon_en | input | 1 | Monitor enable; 0 holds the counter cleared |
| scm_en | input | 1 | Fail policy: 1 requests self-clock mode, 0 requests reset |
| fail_pulse | output | 1 | One-cycle clock-fail event |
| scm_req | output | 1 | Sticky self-clock-mode request |
| rst_req | output | 1 | Sticky system reset request |

## Verification
The bench pins down the exact fail cycle, both from a restart and after a single late oscillator edge. A counter that is off by one, or that adds an extra synchronizer delay, would raise the fail one cycle early or late. It sweeps the oscillator period across the timeout boundary. A design that compares with the wrong bound would fail at P = TIMEOUT or miss P = TIMEOUT + 1. It also holds a stopped oscillator for many timeouts, which exposes a counter that wraps and pulses repeatedly. It drops the enable for a single cycle, which catches a counter that only pauses instead of clearing. It flips the policy after a fail, which shows whether a request is latched or merely follows `scm_en`.

// File: rtl/osc_mon_pkg.sv
package osc_mon_pkg;
  typedef enum logic {
    RESP_RESET = 1'b0,
    RESP_SCM   = 1'b1
  } resp_e;
endpackage

// File: rtl/osc_edge_sync.sv
module osc_edge_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic osc_clk,
  output logic rise
);
  logic [SYNC_STAGES-1:0] chain;
  logic                   last_q;

  genvar i;
  generate
    for (i = 0; i < SYNC_STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[0] <= 1'b0;
          else     chain[0] <= osc_clk;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[i] <= 1'b0;
          else     chain[i] <= chain[i-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) last_q <= 1'b0;
    else     last_q <= chain[SYNC_STAGES-1];
  end

  assign rise = chain[SYNC_STAGES-1] & ~last_q;
endmodule

// File: rtl/osc_timeout_ctr.sv
module osc_timeout_ctr #(
  parameter int TIMEOUT = 1024
) (
  input  logic clk,
  input  logic rst,
  input  logic enable,
  input  logic rise,
  output logic expire
);
  localparam int CW = $clog2(TIMEOUT + 1);
  localparam logic [CW-1:0] LAST = CW'(TIMEOUT - 1);
  localparam logic [CW-1:0] DONE = CW'(TIMEOUT);

  logic [CW-1:0] cnt;

  assign expire = enable && !rise && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst || !enable || rise) cnt <= '0;
    else if (cnt != DONE)       cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/osc_fail_policy.sv
module osc_fail_policy
  import osc_mon_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic expire,
  input  logic scm_en,
  output logic fail_pulse,
  output logic scm_req,
  output logic rst_req
);
  resp_e resp;
  assign resp = scm_en ? RESP_SCM : RESP_RESET;

  always_ff @(posedge clk) begin
    if (rst) begin
      fail_pulse <= 1'b0;
      scm_req    <= 1'b0;
      rst_req    <= 1'b0;
    end else begin
      fail_pulse <= expire;
      if (expire && resp == RESP_SCM)   scm_req <= 1'b1;
      if (expire && resp == RESP_RESET) rst_req <= 1'b1;
    end
  end
endmodule

// File: rtl/osc_loss_monitor.sv
module osc_loss_monitor #(
  parameter int TIMEOUT     = 1024,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic osc_clk,
  input  logic mon_en,
  input  logic scm_en,
  output logic fail_pulse,
  output logic scm_req,
  output logic rst_req
);
  logic rise;
  logic expire;

  osc_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .osc_clk(osc_clk), .rise(rise)
  );

  osc_timeout_ctr #(.TIMEOUT(TIMEOUT)) u_ctr (
    .clk(clk), .rst(rst), .enable(mon_en), .rise(rise), .expire(expire)
  );

  osc_fail_policy u_pol (
    .clk(clk), .rst(rst), .expire(expire), .scm_en(scm_en),
    .fail_pulse(fail_pulse), .scm_req(scm_req), .rst_req(rst_req)
  );
endmodule

// File: rtl/osc_loss_monitor_chk.sv
module osc_loss_monitor_chk (
  input logic clk,
  input logic rst,
  input logic mon_en,
  input logic scm_en,
  input logic fail_pulse,
  input logic scm_req,
  input logic rst_req
);
  assert_single_cycle_fail_R2: assert property (@(posedge clk) disable iff (rst)
    fail_pulse |=> !fail_pulse);

  assert_scm_policy_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(scm_req) |-> fail_pulse && $past(scm_en));

  assert_scm_sticky_R3: assert property (@(posedge clk) disable iff (rst)
    scm_req |=> scm_req);

  assert_rst_policy_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(rst_req) |-> fail_pulse && !$past(scm_en));

  assert_rst_sticky_R4: assert property (@(posedge clk) disable iff (rst)
    rst_req |=> rst_req);

  assert_quiet_when_disabled_R5: assert property (@(posedge clk) disable iff (rst)
    !mon_en |=> !fail_pulse);

  assert_no_req_when_disabled_R5: assert property (@(posedge clk) disable iff (rst)
    (!mon_en && !scm_req && !rst_req) |=> (!scm_req && !rst_req));
endmodule

bind osc_loss_monitor osc_loss_monitor_chk u_chk (
  .clk(clk), .rst(rst), .mon_en(mon_en), .scm_en(scm_en),
  .fail_pulse(fail_pulse), .scm_req(scm_req), .rst_req(rst_req)
);

// File: tb/osc_loss_monitor_test.sv
module osc_loss_monitor_test;
  localparam int T = 12;

  logic clk = 1'b0;
  logic rst, osc_clk, mon_en, scm_en;
  logic fail_pulse, scm_req, rst_req;
  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  osc_loss_monitor #(.TIMEOUT(T), .SYNC_STAGES(2)) uut (
    .clk(clk), .rst(rst), .osc_clk(osc_clk), .mon_en(mon_en), .scm_en(scm_en),
    .fail_pulse(fail_pulse), .scm_req(scm_req), .rst_req(rst_req)
  );

  task automatic step(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    step(3);
    rst = 1'b0;
  endtask

  task automatic outs(input string req, input bit f, input bit s, input bit r);
    check(fail_pulse == f, {req, " fail_pulse"}, fail_pulse, f);
    check(scm_req == s, {req, " scm_req"}, scm_req, s);
    check(rst_req == r, {req, " rst_req"}, rst_req, r);
  endtask

  initial begin
    #(8 * 200000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int bad;
    int pulses;
    rst = 1'b1; osc_clk = 1'b0; mon_en = 1'b1; scm_en = 1'b1;
    @(negedge clk);
    step(3);
    // R7: reset state
    outs("R7 reset", 0, 0, 0);

    // R1 exact latency, R3 self-clock policy
    rst = 1'b0;
    step(T - 1);
    outs("R1 before timeout", 0, 0, 0);
    step(1);
    outs("R1 R3 at timeout", 1, 1, 0);
    step(1);
    check(fail_pulse == 0, "R2 pulse width", fail_pulse, 0);
    bad = 0;
    for (int i = 0; i < 3 * T; i++) begin
      step(1);
      if (fail_pulse) bad++;
      if (!scm_req) bad++;
    end
    check(bad == 0, "R2 R3 no repeat, sticky", bad, 0);

    // R8 re-arm, R4 reset policy while R3 stays latched
    scm_en = 1'b0;
    osc_clk = 1'b1;
    step(1);
    osc_clk = 1'b0;
    step(2);
    step(T - 1);
    check(fail_pulse == 0, "R8 before re-armed timeout", fail_pulse, 0);
    step(1);
    outs("R8 R4 re-armed fail", 1, 1, 1);

    // R7 reset clears latched requests
    do_reset();
    outs("R7 after reset", 0, 0, 0);

    // R4 reset policy from scratch, request does not follow scm_en later
    step(T - 1);
    step(1);
    outs("R4 reset policy", 1, 0, 1);
    scm_en = 1'b1;
    step(T + 3);
    outs("R4 latched, policy flip", 0, 0, 1);

    // R5 disabled monitor
    mon_en = 1'b0;
    do_reset();
    bad = 0;
    for (int i = 0; i < 4 * T; i++) begin
      step(1);
      if (fail_pulse || scm_req || rst_req) bad++;
    end
    check(bad == 0, "R5 disabled quiet", bad, 0);
    // R5 one-cycle drop restarts count
    mon_en = 1'b1;
    step(T - 2);
    mon_en = 1'b0;
    step(1);
    check(fail_pulse == 0, "R5 drop", fail_pulse, 0);
    mon_en = 1'b1;
    step(T - 1);
    check(fail_pulse == 0, "R5 restarted count", fail_pulse, 0);
    step(1);
    outs("R5 full timeout after re-enable", 1, 1, 0);

    // R6 period sweep across the timeout boundary
    for (int p = 2; p <= T + 4; p++) begin
      do_reset();
      pulses = 0;
      for (int k = 0; k < 4 * p + 2 * T; k++) begin
        osc_clk = (k % p == 0);
        step(1);
        if (fail_pulse) pulses++;
      end
      osc_clk = 1'b0;
      check((pulses > 0) == (p > T), $sformatf("R6 period %0d", p),
            pulses, (p > T) ? 1 : 0);
    end

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule